// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator with Clear

This block produces a single active-high pulse whose length is counted in clock cycles. Two trigger inputs of opposite sense start it: a falling edge on the active-low trigger, or a rising edge on the active-high trigger. Each trigger counts only while the other trigger input sits at its asserted level. An active-low clear input overrides everything. While it is low, the pulse is forced off, and any trigger that arrives is ignored. A complementary output is always available.

A trigger that arrives while the pulse is running restarts the count, so the pulse ends a full programmed width after the most recent trigger. The parameter `CLR_FIRES` selects between two variants. With `CLR_FIRES = 1`, letting go of the clear can itself start a pulse, provided both trigger inputs already sit at their asserted levels. With `CLR_FIRES = 0`, releasing the clear never starts a pulse. The inputs are assumed to be synchronous to the clock already.

Top module: `retrig_pulse_gen`

## Requirements
- R1: A high-to-low change on `trig_fall_n` while `trig_rise` is 1 and `clr_n` is 1 starts a pulse. `pulse` reads 1 from the first clock edge after the cycle in which the change is sampled.
- R2: A low-to-high change on `trig_rise` while `trig_fall_n` is 0 and `clr_n` is 1 starts a pulse with the same timing as R1.
- R3: A falling `trig_fall_n` while `trig_rise` is 0 starts no pulse. A rising `trig_rise` while `trig_fall_n` is 1 starts no pulse.
- R4: After a single trigger, `pulse` stays 1 for exactly `width` clock cycles, where `width` is an unsigned 16-bit value sampled with the trigger. A `width` of 0 gives a pulse of one cycle.
- R5: A qualifying trigger while `pulse` is 1 reloads the full width from that trigger, so `pulse` stays 1 until `width` cycles after the last trigger. This holds even when the trigger lands in the final cycle of the pulse: `pulse` does not drop.
- R6: While `clr_n` is 0, `pulse` is 0 and `pulse_n` is 1 in the same cycle, without waiting for a clock edge. The running pulse is ended, and triggers that arrive meanwhile start nothing.
- R7: With `CLR_FIRES = 1`, a low-to-high change on `clr_n` while `trig_fall_n` is 0 and `trig_rise` is 1 starts a pulse with R1 timing. With `CLR_FIRES = 0`, the same stimulus leaves `pulse` at 0.
- R8: `pulse_n` is always the inverse of `pulse`. With no trigger, `pulse` rests at 0.
- R9: A synchronous active-low `rst_n` clears the count and the edge history. Input levels that are steady at the moment reset is released start no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_fall_n | input | 1 | Trigger input that acts on its falling edge |
| trig_rise | input | 1 | Trigger input that acts on its rising edge |
| clr_n | input | 1 | Overriding clear, active low |
| width | input | WIDTH_W | Pulse length in clock cycles; 0 is taken as 1 |
| pulse | output | 1 | Pulse output, active high |
| pulse_n | output | 1 | Inverse of `pulse` |

## Verification
The hardest case to reach is a retrigger that lands in the very last cycle of a pulse, where the reload and the terminal count meet on the same edge. The bench drives the trigger one cycle before the pulse would end. This timing is derived from the one-register latency between sampling and output. The bench then checks that `pulse` stays high with no gap through the full reloaded width. Two instances with opposite `CLR_FIRES` settings receive identical stimulus, so a single clear release shows both the variant that fires and the one that stays quiet.

// File: rtl/os_pkg.sv
// Package: shared types for the one-shot pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package os_pkg;

    // One flag per detected input transition, all valid in the same cycle.
    typedef struct packed {
        logic a_fall;   // trigger_fall_n went 1 -> 0
        logic b_rise;   // trigger_rise went 0 -> 1
        logic r_rise;   // clear went 0 -> 1 (released)
    } os_edges_t;

endpackage

// File: rtl/os_edge_detect.sv
// Module: os_edge_detect
// Registers each control input once and flags its transitions by comparing the
// current value with the registered one. Assumes inputs are synchronous to clk.
// The reset values are chosen so that no level present at reset release looks
// like an edge.
module os_edge_detect
    import os_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_n_i,
    input  logic      b_i,
    input  logic      r_n_i,
    output os_edges_t edges_o
);

    logic a_q;
    logic b_q;
    logic r_q;

    // Purpose: keep the previous-cycle value of every control input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b1;
            r_q <= 1'b1;
        end else begin
            a_q <= a_n_i;
            b_q <= b_i;
            r_q <= r_n_i;
        end
    end

    // Purpose: flag transitions from the previous value to the current one.
    always_comb begin
        edges_o.a_fall = a_q & ~a_n_i;
        edges_o.b_rise = ~b_q & b_i;
        edges_o.r_rise = ~r_q & r_n_i;
    end

    // R9: the first cycle after reset release reports no edge.
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (edges_o == '0));

endmodule

// File: rtl/os_trig_qual.sv
// Module: os_trig_qual
// Turns detected edges into a single start request, applying the cross-gating
// between the two trigger inputs and the clear. CLR_FIRES selects whether a
// release of the clear may start a pulse.
module os_trig_qual
    import os_pkg::*;
#(
    parameter bit CLR_FIRES = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  os_edges_t edges_i,
    input  logic      a_n_i,
    input  logic      b_i,
    input  logic      r_n_i,
    output logic      fire_o
);

    logic rel_fire;

    // Purpose: choose the clear-release start path for the selected variant.
    generate
        if (CLR_FIRES) begin : g_rel_on
            always_comb rel_fire = edges_i.r_rise & ~a_n_i & b_i;
        end else begin : g_rel_off
            always_comb rel_fire = 1'b0;
            // R7: in this variant a clear release alone never starts a pulse.
            a_r7_release_inert: assert property (@(posedge clk) disable iff (!rst_n)
                (edges_i.r_rise && !edges_i.a_fall && !edges_i.b_rise) |-> !fire_o);
        end
    endgenerate

    // Purpose: combine the gated trigger edges into one start request.
    always_comb begin
        fire_o = (r_n_i & ((edges_i.a_fall & b_i) | (edges_i.b_rise & ~a_n_i)))
               | rel_fire;
    end

    // R6: no start request is ever issued while the clear is held low.
    a_r6_no_fire_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !r_n_i |-> !fire_o);

    // R3: a trigger edge whose partner input is not asserted starts nothing.
    a_r3_gated_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!edges_i.r_rise && ((edges_i.a_fall && !b_i) || (edges_i.b_rise && a_n_i))
         && !(edges_i.a_fall && edges_i.b_rise)) |-> !fire_o);

endmodule

// File: rtl/os_width_counter.sv
// Module: os_width_counter
// Down-counter that holds the remaining pulse length. A load takes priority
// over the terminal count, so a retrigger in the last cycle continues the
// pulse seamlessly. A width of zero is loaded as one.
module os_width_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          clr_n_i,
    input  logic [CW-1:0] width_i,
    output logic          busy_o
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt;
    logic [CW-1:0] width_eff;

    // Purpose: map a requested width of zero to the shortest legal pulse.
    always_comb width_eff = (width_i == '0) ? ONE : width_i;

    // Purpose: clear, reload on a start request, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!clr_n_i) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= width_eff;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    // Purpose: the pulse is active while cycles remain.
    always_comb busy_o = (cnt != '0);

    // R4: a start loads the requested width, with zero taken as one.
    a_r4_load_width: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && clr_n_i) |=>
            (cnt == (($past(width_i) == '0) ? ONE : $past(width_i))));

    // R4: with no start and no clear, a running count drops by one per cycle.
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt != '0) && !load_i && clr_n_i) |=> (cnt == $past(cnt) - ONE));

    // R5: a retrigger in the final cycle keeps the pulse active.
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == ONE) && load_i && clr_n_i) |=> busy_o);

    // R6: a held clear empties the counter at the next edge.
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> (cnt == '0));

endmodule

// File: rtl/retrig_pulse_gen.sv
// Module: retrig_pulse_gen
// Retriggerable one-shot with overriding clear. Inputs must already be
// synchronous to clk. The output rises one edge after a qualifying input
// change is sampled. The clear gates the output combinationally, so it cuts
// the pulse in the same cycle.
module retrig_pulse_gen
    import os_pkg::*;
#(
    parameter int unsigned WIDTH_W   = 16,
    parameter bit          CLR_FIRES = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_fall_n,
    input  logic               trig_rise,
    input  logic               clr_n,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse,
    output logic               pulse_n
);

    os_edges_t edges;
    logic      fire;
    logic      busy;

    os_edge_detect u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_n_i   (trig_fall_n),
        .b_i     (trig_rise),
        .r_n_i   (clr_n),
        .edges_o (edges)
    );

    os_trig_qual #(.CLR_FIRES(CLR_FIRES)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .edges_i (edges),
        .a_n_i   (trig_fall_n),
        .b_i     (trig_rise),
        .r_n_i   (clr_n),
        .fire_o  (fire)
    );

    os_width_counter #(.CW(WIDTH_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (fire),
        .clr_n_i (clr_n),
        .width_i (width),
        .busy_o  (busy)
    );

    // Purpose: drive the complementary outputs, with the clear overriding.
    always_comb begin
        pulse   = busy & clr_n;
        pulse_n = ~pulse;
    end

    // R1: the count only starts after a start request on the previous edge.
    a_r1_start_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(fire));

    // R8: with no count running, the output rests low.
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pulse && pulse_n));

endmodule

// File: tb/retrig_pulse_gen_bench.sv
module retrig_pulse_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_n;
    logic        b;
    logic        r_n;
    logic [15:0] w;
    logic        q1, qn1, q0, qn0;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    // Variant in which releasing the clear may start a pulse.
    retrig_pulse_gen #(.WIDTH_W(16), .CLR_FIRES(1'b1)) u_retrig_pulse_gen (
        .clk(clk), .rst_n(rst_n), .trig_fall_n(a_n), .trig_rise(b), .clr_n(r_n),
        .width(w), .pulse(q1), .pulse_n(qn1));

    // Variant in which releasing the clear never starts a pulse.
    retrig_pulse_gen #(.WIDTH_W(16), .CLR_FIRES(1'b0)) u_retrig_pulse_gen_nr (
        .clk(clk), .rst_n(rst_n), .trig_fall_n(a_n), .trig_rise(b), .clr_n(r_n),
        .width(w), .pulse(q0), .pulse_n(qn0));

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // R8: outputs of both instances are complementary.
    task automatic chk_pair(input string req, input logic e1, input logic e0);
        chk(req, q1, e1);
        chk(req, q0, e0);
        chk("R8", qn1, ~q1);
        chk("R8", qn0, ~q0);
    endtask

    task automatic idle_low(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk_pair(req, 1'b0, 1'b0);
        end
    endtask

    // Start from a=1,b=1,r=1. Fall a, optionally fall again at cycle kt.
    // The output is expected high from cycle 1 through cycle last + weff.
    task automatic a_trigger(input string req, input int wd, input int kt);
        int weff;
        int last;
        weff = (wd == 0) ? 1 : wd;
        last = (kt >= 2) ? kt : 0;
        w = 16'(wd);
        a_n = 1'b0;
        for (int k = 1; k <= last + weff + 2; k++) begin
            @(negedge clk);
            chk_pair(req, k <= last + weff, k <= last + weff);
            if (k == 1) a_n = 1'b1;
            if (kt >= 2 && k == kt) a_n = 1'b0;
            if (kt >= 2 && k == kt + 1) a_n = 1'b1;
        end
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a_n = 1'b1; b = 1'b1; r_n = 1'b1; w = 16'd3;
        @(negedge clk);
        @(negedge clk);
        chk_pair("R9 reset state", 1'b0, 1'b0);
        // Levels a=0,b=1 held through reset release must not start a pulse.
        a_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle_low("R9 no start after reset", 4);
        a_n = 1'b1;
        idle_low("R8 idle", 2);

        // R1 and R4: width sweep via the falling trigger.
        for (int wd = 0; wd <= 7; wd++) a_trigger("R1 R4 width sweep", wd, 0);
        a_trigger("R4 wide width", 300, 0);

        // R5: retriggers mid-pulse and in the last cycle.
        a_trigger("R5 retrigger mid", 5, 3);
        a_trigger("R5 retrigger last cycle", 3, 3);
        a_trigger("R5 retrigger last cycle", 2, 2);

        // R2: rising trigger with the other trigger held low.
        a_n = 1'b0; b = 1'b0;
        idle_low("R8 idle", 2);
        for (int wd = 1; wd <= 4; wd++) begin
            w = 16'(wd);
            b = 1'b1;
            for (int k = 1; k <= wd + 2; k++) begin
                @(negedge clk);
                chk_pair("R2 rising trigger", k <= wd, k <= wd);
                if (k == 1) b = 1'b0;
            end
        end

        // R3: blocked edges.
        a_n = 1'b1; b = 1'b0; w = 16'd3;
        idle_low("R3", 2);
        a_n = 1'b0;
        idle_low("R3 fall blocked by low partner", 3);
        a_n = 1'b1;
        idle_low("R3", 1);
        b = 1'b1;
        idle_low("R3 rise blocked by high partner", 3);

        // R6: clear cuts a pulse at once and blocks triggers.
        w = 16'd10;
        a_n = 1'b0;
        @(negedge clk);
        a_n = 1'b1;
        chk_pair("R6 pulse running", 1'b1, 1'b1);
        @(negedge clk);
        r_n = 1'b0;
        #1;
        chk_pair("R6 same-cycle cut", 1'b0, 1'b0);
        idle_low("R6 held clear", 2);
        a_n = 1'b0;
        idle_low("R6 trigger ignored in clear", 2);
        a_n = 1'b1;
        idle_low("R6 trigger ignored in clear", 2);
        r_n = 1'b1;
        idle_low("R6 release with partner high, no start", 4);

        // R7: release of clear with both triggers asserted.
        w = 16'd4;
        r_n = 1'b0;
        @(negedge clk);
        a_n = 1'b0; b = 1'b1;
        idle_low("R7 setup", 2);
        r_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk_pair("R7 release variants", k <= 4, 1'b0);
        end
        a_n = 1'b1;
        idle_low("R8 idle end", 3);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule